// File: doc/BRIEF.md
# TDD Timing Sequence Controller

This block produces a group of timed control lines that repeat inside a frame, for a time-division-duplex front end. Software (through a register bank outside this block) sets the frame length, an optional startup delay, a burst length in frames and an on/off window for each channel. It then raises `enable`. The controller arms and, if asked to, waits for an external synchronization pulse. It then counts out the startup delay and runs frames until the burst is used up or the block is disabled.

Every channel output is the build-time idle level, inverted while the frame counter lies inside that channel's window. The sync input may come from another clock domain, so it passes through a synchronizer before use. While frames are running, the same sync edge can optionally pull the frame counter back to zero. The current state and the build-time idle level are reported on read-only outputs.

Top module: `tdd_sequencer`

## Requirements
- R1: After reset `state` reads IDLE and `chOut` equals the idle level. The state codes are IDLE=0, ARMED=1, WAITING=2 and RUNNING=3.
- R2: `idleLevel` always reports the build-time parameter `IDLE_LEVEL`. In any cycle after one where the state was not RUNNING, `chOut` equals `IDLE_LEVEL`.
- R3: The controller leaves IDLE for ARMED only on a rising edge of `enable`, so a level held high after a finished burst does not re-arm it. Dropping `enable` in ARMED or WAITING returns the state to IDLE on the next clock.
- R4: With `extSyncEn` low, ARMED lasts exactly one cycle. With it high, ARMED holds until a rising edge of `syncIn`. After a two-stage synchronizer, the state advances on the third clock edge after `syncIn` is first sampled high.
- R5: A `startDelay` of zero moves the state from ARMED straight to RUNNING. Otherwise the state stays in WAITING for exactly `startDelay` cycles before RUNNING.
- R6: In RUNNING the frame counter steps from 0 to `frameLen`−1 and wraps to 0. `frameLen` must be at least 1.
- R7: Channel i outputs `IDLE_LEVEL[i] XOR (on_i ≤ count < off_i)`. The output is registered, so it shows the count from the previous cycle. `on_i` is bits [i*CNT_W +: CNT_W] of `chOn`, and `off_i` is the same slice of `chOff`.
- R8: A non-zero `burstCount` of N runs exactly N frames (N·`frameLen` RUNNING cycles) and then returns to IDLE. A `burstCount` of zero runs frames without end.
- R9: If `enable` falls while RUNNING, the current frame completes and the state returns to IDLE after the cycle with count `frameLen`−1.
- R10: With `syncRstEn` high, a synchronized rising edge of `syncIn` during RUNNING forces the count to 0 on that edge, in place of the increment. With `syncRstEn` low, such an edge has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms on rising edge; low stops the sequence |
| extSyncEn | input | 1 | ARMED waits for a sync edge when high |
| syncRstEn | input | 1 | Sync edge restarts the frame count while running |
| syncIn | input | 1 | Asynchronous synchronization pulse |
| frameLen | input | CNT_W | Frame length in cycles |
| startDelay | input | CNT_W | Cycles spent in WAITING |
| burstCount | input | BURST_W | Frames per burst, 0 = endless |
| chOn | input | NUM_CH*CNT_W | Per-channel window start |
| chOff | input | NUM_CH*CNT_W | Per-channel window end (exclusive) |
| chOut | output | NUM_CH | Timed channel outputs |
| state | output | 2 | Current state code |
| idleLevel | output | NUM_CH | Build-time default polarity |

## Verification
The bench targets the zero-delay shortcut: a design that always passes through WAITING would show one WAITING cycle where none is allowed. It drops `enable` mid-frame, where an early stop would cut the frame short and a missed check would keep running. It also checks that a burst ends on the exact frame boundary, since an off-by-one in the burst count adds or drops a frame. It pulses sync during running with restart both enabled and disabled, where a wrong synchronizer depth or a restart that ignores its enable shifts the channel pattern by a visible number of cycles.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_WAITING = 2'd2,
    ST_RUNNING = 2'd3
  } tddState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic delayInc;
    logic frameInc;
    logic frameRestart;
    logic burstLoad;
    logic burstDec;
    logic outEn;
  } tddStrobe_t;

endpackage

// File: rtl/tdd_sync_edge.sv
module tdd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic edgeOut
);

  logic [STAGES-1:0] chain;
  logic              lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain     <= '0;
      lastLevel <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], asyncIn};
      lastLevel <= chain[STAGES-1];
    end
  end

  assign edgeOut = chain[STAGES-1] & ~lastLevel;

endmodule

// File: rtl/tdd_datapath.sv
module tdd_datapath
  import tdd_seq_pkg::*;
#(
  parameter int                NUM_CH     = 4,
  parameter int                CNT_W      = 16,
  parameter int                BURST_W    = 8,
  parameter logic [NUM_CH-1:0] IDLE_LEVEL = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tddStrobe_t              strobe,
  input  logic [CNT_W-1:0]        frameLen,
  input  logic [CNT_W-1:0]        startDelay,
  input  logic [BURST_W-1:0]      burstCount,
  input  logic [NUM_CH*CNT_W-1:0] chOn,
  input  logic [NUM_CH*CNT_W-1:0] chOff,
  output logic                    delayZero,
  output logic                    delayDone,
  output logic                    frameEnd,
  output logic                    infiniteBurst,
  output logic                    lastFrame,
  output logic [NUM_CH-1:0]       chOut
);

  localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
  localparam logic [BURST_W-1:0] BURST_ONE = BURST_W'(1);

  logic [CNT_W-1:0]   delayCnt;
  logic [CNT_W-1:0]   frameCnt;
  logic [BURST_W-1:0] burstLeft;
  logic [NUM_CH-1:0]  inWindow;

  assign delayZero     = (startDelay == '0);
  assign delayDone     = (delayCnt == startDelay - CNT_ONE);
  assign frameEnd      = (frameCnt == frameLen - CNT_ONE);
  assign infiniteBurst = (burstCount == '0);
  assign lastFrame     = (burstLeft == BURST_ONE);

  always_ff @(posedge clk) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.clrAll)    delayCnt <= '0;
    else if (strobe.delayInc)  delayCnt <= delayCnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      frameCnt <= '0;
    else if (strobe.clrAll || strobe.frameRestart)
      frameCnt <= '0;
    else if (strobe.frameInc)
      frameCnt <= frameEnd ? '0 : frameCnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 burstLeft <= '0;
    else if (strobe.burstLoad) burstLeft <= burstCount;
    else if (strobe.burstDec)  burstLeft <= burstLeft - BURST_ONE;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [CNT_W-1:0] onTime;
    logic [CNT_W-1:0] offTime;
    assign onTime      = chOn[i*CNT_W +: CNT_W];
    assign offTime     = chOff[i*CNT_W +: CNT_W];
    assign inWindow[i] = (frameCnt >= onTime) && (frameCnt < offTime);

    always_ff @(posedge clk) begin
      if (!rstN) chOut[i] <= IDLE_LEVEL[i];
      else       chOut[i] <= IDLE_LEVEL[i] ^ (strobe.outEn & inWindow[i]);
    end
  end

endmodule

// File: rtl/tdd_ctrl.sv
module tdd_ctrl
  import tdd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       extSyncEn,
  input  logic       syncRstEn,
  input  logic       syncEdge,
  input  logic       delayZero,
  input  logic       delayDone,
  input  logic       frameEnd,
  input  logic       infiniteBurst,
  input  logic       lastFrame,
  output tddStrobe_t strobe,
  output tddState_t  state
);

  tddState_t nextState;
  logic      enPrev;
  logic      enRise;

  assign enRise = enable & ~enPrev;

  always_comb begin
    nextState    = state;
    strobe       = '0;
    strobe.outEn = (state == ST_RUNNING);
    unique case (state)
      ST_IDLE: begin
        if (enRise) begin
          nextState     = ST_ARMED;
          strobe.clrAll = 1'b1;
        end
      end
      ST_ARMED: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (!extSyncEn || syncEdge) begin
          strobe.clrAll    = 1'b1;
          strobe.burstLoad = 1'b1;
          nextState        = delayZero ? ST_RUNNING : ST_WAITING;
        end
      end
      ST_WAITING: begin
        if (!enable)        nextState = ST_IDLE;
        else if (delayDone) nextState = ST_RUNNING;
        else                strobe.delayInc = 1'b1;
      end
      ST_RUNNING: begin
        if (syncRstEn && syncEdge) begin
          strobe.frameRestart = 1'b1;
        end else begin
          strobe.frameInc = 1'b1;
          if (frameEnd) begin
            if (!enable || (!infiniteBurst && lastFrame))
              nextState = ST_IDLE;
            else if (!infiniteBurst)
              strobe.burstDec = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enable;
    end
  end

endmodule

// File: rtl/tdd_sequencer.sv
module tdd_sequencer
  import tdd_seq_pkg::*;
#(
  parameter int                NUM_CH      = 4,
  parameter int                CNT_W       = 16,
  parameter int                BURST_W     = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_CH-1:0] IDLE_LEVEL  = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    extSyncEn,
  input  logic                    syncRstEn,
  input  logic                    syncIn,
  input  logic [CNT_W-1:0]        frameLen,
  input  logic [CNT_W-1:0]        startDelay,
  input  logic [BURST_W-1:0]      burstCount,
  input  logic [NUM_CH*CNT_W-1:0] chOn,
  input  logic [NUM_CH*CNT_W-1:0] chOff,
  output logic [NUM_CH-1:0]       chOut,
  output logic [1:0]              state,
  output logic [NUM_CH-1:0]       idleLevel
);

  tddStrobe_t strobe;
  tddState_t  curState;
  logic       syncEdge;
  logic       delayZero;
  logic       delayDone;
  logic       frameEnd;
  logic       infiniteBurst;
  logic       lastFrame;

  assign state     = curState;
  assign idleLevel = IDLE_LEVEL;

  tdd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (syncIn),
    .edgeOut (syncEdge)
  );

  tdd_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .extSyncEn     (extSyncEn),
    .syncRstEn     (syncRstEn),
    .syncEdge      (syncEdge),
    .delayZero     (delayZero),
    .delayDone     (delayDone),
    .frameEnd      (frameEnd),
    .infiniteBurst (infiniteBurst),
    .lastFrame     (lastFrame),
    .strobe        (strobe),
    .state         (curState)
  );

  tdd_datapath #(
    .NUM_CH     (NUM_CH),
    .CNT_W      (CNT_W),
    .BURST_W    (BURST_W),
    .IDLE_LEVEL (IDLE_LEVEL)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .frameLen      (frameLen),
    .startDelay    (startDelay),
    .burstCount    (burstCount),
    .chOn          (chOn),
    .chOff         (chOff),
    .delayZero     (delayZero),
    .delayDone     (delayDone),
    .frameEnd      (frameEnd),
    .infiniteBurst (infiniteBurst),
    .lastFrame     (lastFrame),
    .chOut         (chOut)
  );

endmodule

// File: rtl/tdd_sequencer_checker.sv
module tdd_sequencer_checker
  import tdd_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [CNT_W-1:0]  startDelay,
  input logic [1:0]        state,
  input logic [NUM_CH-1:0] chOut,
  input logic [NUM_CH-1:0] idleLevel
);

  // R2: outputs rest at the idle level after any non-running cycle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUNNING) |=> (chOut == idleLevel));

  // R3: IDLE with enable low stays IDLE
  p_no_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));

  // R3: disable while armed drops to IDLE
  p_disarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && !enable) |=> (state == ST_IDLE));

  // R5: zero delay never visits WAITING
  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && startDelay == '0) |=> (state != ST_WAITING));

  // R5: WAITING never falls back to ARMED
  p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITING) |=> (state != ST_ARMED));

  // R9: RUNNING leaves only to IDLE
  p_run_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUNNING) |=> (state == ST_RUNNING || state == ST_IDLE));

endmodule

bind tdd_sequencer tdd_sequencer_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .startDelay (startDelay),
  .state      (state),
  .chOut      (chOut),
  .idleLevel  (idleLevel)
);

// File: tb/test_tdd_sequencer.sv
module test_tdd_sequencer;

  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int BW  = 4;
  localparam logic [NCH-1:0] IDLE = 4'b0110;
  localparam int FLEN = 8;

  localparam logic [1:0] S_IDLE = 2'd0, S_ARMED = 2'd1, S_WAIT = 2'd2, S_RUN = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, extSyncEn = 1'b0, syncRstEn = 1'b0, syncIn = 1'b0;
  logic [CW-1:0] frameLen = CW'(FLEN);
  logic [CW-1:0] startDelay = '0;
  logic [BW-1:0] burstCount = '0;
  // windows ch3..ch0: [5,5) [4,7) [0,2) [1,3)
  logic [NCH*CW-1:0] chOn  = {8'd5, 8'd4, 8'd0, 8'd1};
  logic [NCH*CW-1:0] chOff = {8'd5, 8'd7, 8'd2, 8'd3};
  logic [NCH-1:0] chOut, idleLevel;
  logic [1:0] state;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tdd_sequencer #(
    .NUM_CH(NCH), .CNT_W(CW), .BURST_W(BW), .SYNC_STAGES(2), .IDLE_LEVEL(IDLE)
  ) i_tdd_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .extSyncEn(extSyncEn),
    .syncRstEn(syncRstEn), .syncIn(syncIn), .frameLen(frameLen),
    .startDelay(startDelay), .burstCount(burstCount), .chOn(chOn),
    .chOff(chOff), .chOut(chOut), .state(state), .idleLevel(idleLevel)
  );

  function automatic logic [NCH-1:0] expOut(int c);
    logic [NCH-1:0] w;
    w[0] = (c >= 1 && c < 3);
    w[1] = (c < 2);
    w[2] = (c >= 4 && c < 7);
    w[3] = 1'b0;
    return IDLE ^ w;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitState(input logic [1:0] st, input int maxCyc, input string req);
    int n = 0;
    while (state != st && n < maxCyc) begin
      tick();
      n++;
    end
    check(state == st, req, state, st);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // R1 R2
  task automatic t_reset();
    check(state == S_IDLE, "R1 reset state", state, S_IDLE);
    check(chOut == IDLE, "R1 reset outputs", chOut, IDLE);
    check(idleLevel == IDLE, "R2 idle level port", idleLevel, IDLE);
  endtask

  // R3 R5 R6 R7 R8: zero delay, two-frame burst
  task automatic t_zero_delay_burst();
    extSyncEn = 0; startDelay = '0; burstCount = 4'd2;
    enable = 1;
    tick();
    check(state == S_ARMED, "R3 armed on rise", state, S_ARMED);
    tick();
    check(state == S_RUN, "R5 zero delay goes running", state, S_RUN);
    for (int j = 1; j <= 2*FLEN; j++) begin
      tick();
      if (j < 2*FLEN) check(state == S_RUN, "R8 running within burst", state, S_RUN);
      else            check(state == S_IDLE, "R8 idle after two frames", state, S_IDLE);
      check(chOut == expOut((j-1) % FLEN), "R7 R6 channel pattern", chOut, expOut((j-1) % FLEN));
    end
    tick();
    check(chOut == IDLE, "R2 idle after burst", chOut, IDLE);
    repeat (4) tick();
    check(state == S_IDLE, "R3 level enable does not re-arm", state, S_IDLE);
    enable = 0;
    tick();
  endtask

  // R5 R8: start delay of five, single frame
  task automatic t_start_delay();
    int nWait = 0;
    int nRun = 0;
    startDelay = 8'd5; burstCount = 4'd1; extSyncEn = 0;
    enable = 1;
    tick();
    check(state == S_ARMED, "R3 armed", state, S_ARMED);
    tick();
    while (state == S_WAIT && nWait < 50) begin nWait++; tick(); end
    check(nWait == 5, "R5 waiting cycles", nWait, 5);
    check(state == S_RUN, "R5 running after delay", state, S_RUN);
    while (state == S_RUN && nRun < 50) begin nRun++; tick(); end
    check(nRun == FLEN, "R8 one frame burst length", nRun, FLEN);
    enable = 0; startDelay = '0;
    tick();
  endtask

  // R4: armed waits for sync edge
  task automatic t_sync_arm();
    extSyncEn = 1; burstCount = 4'd1;
    enable = 1;
    tick();
    repeat (6) tick();
    check(state == S_ARMED, "R4 armed holds without sync", state, S_ARMED);
    syncIn = 1;
    tick();
    check(state == S_ARMED, "R4 sync stage one", state, S_ARMED);
    tick();
    check(state == S_ARMED, "R4 sync stage two", state, S_ARMED);
    tick();
    check(state == S_RUN, "R4 running on third edge", state, S_RUN);
    syncIn = 0;
    waitState(S_IDLE, 20, "R8 sync-started burst ends");
    enable = 0; extSyncEn = 0;
    repeat (3) tick();
  endtask

  // R3: disable while armed
  task automatic t_disarm();
    extSyncEn = 1;
    enable = 1;
    tick();
    check(state == S_ARMED, "R3 armed before disable", state, S_ARMED);
    enable = 0;
    tick();
    check(state == S_IDLE, "R3 disable in armed", state, S_IDLE);
    extSyncEn = 0;
    tick();
  endtask

  // R8 R9: endless burst, disabled mid-frame
  task automatic t_disable_midframe();
    burstCount = '0; startDelay = '0;
    enable = 1;
    tick(); tick();
    check(state == S_RUN, "R9 enter running", state, S_RUN);
    repeat (20) tick();
    check(state == S_RUN, "R8 zero burst keeps running", state, S_RUN);
    enable = 0;  // count is 4 here
    for (int j = 21; j <= 23; j++) begin
      tick();
      check(state == S_RUN, "R9 frame completes", state, S_RUN);
    end
    tick();
    check(state == S_IDLE, "R9 idle at frame end", state, S_IDLE);
    check(chOut == expOut(FLEN-1), "R9 last count output", chOut, expOut(FLEN-1));
    tick();
    check(chOut == IDLE, "R2 idle after stop", chOut, IDLE);
  endtask

  // R10: sync restart enabled or ignored
  task automatic t_sync_restart(input bit rstEn);
    int c = 0;
    int cPrev;
    syncRstEn = rstEn; burstCount = '0;
    enable = 1;
    tick(); tick();
    for (int j = 1; j <= 12; j++) begin
      if (j == 3) syncIn = 1;
      if (j == 4) syncIn = 0;
      tick();
      cPrev = c;
      c = (rstEn && j == 5) ? 0 : (c + 1) % FLEN;
      check(chOut == expOut(cPrev), rstEn ? "R10 restart pattern" : "R10 ignored pattern",
            chOut, expOut(cPrev));
    end
    enable = 0;
    waitState(S_IDLE, 20, "R9 stop after restart test");
    syncRstEn = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick();
    t_reset();
    t_zero_delay_burst();
    t_start_delay();
    t_sync_arm();
    t_disarm();
    t_disable_midframe();
    t_sync_restart(1'b1);
    t_sync_restart(1'b0);
    finishUp();
  end

endmodule